// File: doc/BRIEF.md
# Edge-Counting Pulse Divider

This block divides a slow, free-running input signal (`tick_in`) by a programmable 32-bit ratio. The fast system clock `clk` samples `tick_in` through a short synchronizer and detects its rising transitions. A transition counts only while `en` is high. Each counted transition moves a down counter. On every Nth counted transition the output `q` goes high, and the next counted transition brings it low again. The output therefore shows exactly one rising edge per N input rising edges, and each high phase lasts one input period.

A ratio of zero selects a pass-through mode. In this mode `q` copies the synchronized input, gated by `en`. The `reload` input restarts the division period from the current ratio and does not change `q`. A ratio written while the divider runs takes effect at the next reload of the counter. That reload happens either on the transition that raises `q` or on a `reload` pulse.

Top module: `edge_div_pulser`

## Requirements
- R1: Every 0-to-1 change of `tick_in`, held for at least three `clk` cycles (two synchronizer stages), is seen as one input edge. `q` shows the result of that edge three `clk` rising edges after `tick_in` changes.
- R2: While `en` is 0, input edges are ignored. `q` does not change and the division count does not advance.
- R3: With `n_val` of 2 or more, starting from a reload, `q` rises on every `n_val`-th counted edge. After E counted edges, `q` has risen floor(E / `n_val`) times.
- R4: With `n_val` not 0, a `q` that is 1 returns to 0 on the next counted edge, and that edge still advances the count.
- R5: With `n_val` equal to 1, `q` toggles on every counted edge. After E counted edges from a reload, `q` has risen ceil(E / 2) times.
- R6: With `n_val` equal to 0, `q` equals `tick_in` AND `en`, delayed by the same latency as R1.
- R7: A one-cycle high on `reload` (synchronous to `clk`) reloads the count from `n_val`. `q` next rises after `n_val` further counted edges, and `reload` itself leaves `q` unchanged.
- R8: After a reload while `q` is 1, the first counted edge clears `q` and is the first of the `n_val` edges that lead to the next rise.
- R9: A change of `n_val` in divide mode does not cut short the running period. The new value takes effect at the next reload, either the edge that raises `q` or a `reload` pulse.
- R10: A high `rst` at a `clk` edge sets `q` to 0 and loads the count from `n_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Input signal whose rising edges are divided |
| en | input | 1 | Counting and pass-through enable |
| reload | input | 1 | Restart the division period from `n_val` |
| n_val | input | 32 | Division ratio; 0 selects pass-through |
| q | output | 1 | Divided output, registered |

## Verification
The bench sweeps ratios 1 through 6 over more edges than two periods. It compares the number of `q` rising edges with the floor and ceiling formulas, so an off-by-one reload value shows up as a rise count that drifts with each period. The ratio of 1 catches a design in which the clearing edge does not win over a fire, because `q` would then stay high. The bench toggles `en`, pulses `reload` while `q` is high, and changes the ratio in the middle of a period. A design that counts disabled edges, clears `q` on reload, or applies a new ratio at once would fire on the wrong edge. In pass-through mode with `en` low, a bypass that ignores the enable would copy the input to `q`.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  typedef enum logic {
    DBN_DIVIDE = 1'b0,
    DBN_BYPASS = 1'b1
  } dbn_mode_e;
endpackage

// File: rtl/dbn_edge_sync.sv
module dbn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic prev;

  generate
    if (STAGES == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b0;
        else     stage_q <= din;
      end
      assign level = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
      assign level = pipe[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign rise = level & ~prev;

  // one detection per input transition
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dbn_down_counter.sv
module dbn_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] n_val,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic             last;

  assign last = (remain <= ONE);
  assign fire = step & ~reload & last;

  always_ff @(posedge clk) begin
    if (rst || reload)  remain <= n_val;
    else if (step)      remain <= last ? n_val : remain - ONE;
  end

  assert_reload_value_R7: assert property (@(posedge clk) disable iff (rst)
    reload |=> (remain == $past(n_val)));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!step && !reload) |=> $stable(remain));
endmodule

// File: rtl/dbn_pulse_out.sv
module dbn_pulse_out
  import dbn_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dbn_mode_e mode,
  input  logic      step,
  input  logic      fire,
  input  logic      pass_level,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (rst)                     q <= 1'b0;
    else if (mode == DBN_BYPASS) q <= pass_level;
    else if (step)               q <= q ? 1'b0 : fire;
  end

  assert_clear_next_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == DBN_DIVIDE && step && q) |=> !q);
  assert_quiet_divide_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == DBN_DIVIDE && !step) |=> $stable(q));
endmodule

// File: rtl/edge_div_pulser.sv
module edge_div_pulser
  import dbn_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             en,
  input  logic             reload,
  input  logic [CNT_W-1:0] n_val,
  output logic             q
);
  logic      tick_level;
  logic      tick_rise;
  logic      step;
  logic      fire;
  dbn_mode_e mode;

  dbn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (tick_in),
    .level (tick_level),
    .rise  (tick_rise)
  );

  assign mode = (n_val == '0) ? DBN_BYPASS : DBN_DIVIDE;
  assign step = tick_rise & en & (mode == DBN_DIVIDE);

  dbn_down_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .reload (reload),
    .n_val  (n_val),
    .fire   (fire)
  );

  dbn_pulse_out u_out (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .step       (step),
    .fire       (fire),
    .pass_level (tick_level & en),
    .q          (q)
  );

  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(step) || $past(mode == DBN_BYPASS)));
  assert_bypass_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == DBN_BYPASS && !en) |=> !q);
  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && mode == DBN_DIVIDE) |=> $stable(q));
  assert_reload_keeps_q_R7: assert property (@(posedge clk) disable iff (rst)
    (reload && !step && mode == DBN_DIVIDE) |=> $stable(q));
endmodule

// File: tb/test_edge_div_pulser.sv
module test_edge_div_pulser;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        en = 1'b1;
  logic        reload = 1'b0;
  logic [31:0] nv = 32'd5;
  logic        q;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  logic q_prev = 1'b0;
  bit finished = 0;

  logic        m_q;
  int unsigned m_cnt;

  edge_div_pulser i_edge_div_pulser (
    .clk(clk), .rst(rst), .tick_in(tick), .en(en),
    .reload(reload), .n_val(nv), .q(q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && q && !q_prev) rises++;
    q_prev = q;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit fire;
    if (!en) return;
    if (nv == 0) begin
      m_q = 1'b1;
    end else begin
      fire = (m_cnt <= 1);
      m_cnt = fire ? nv : m_cnt - 1;
      m_q = m_q ? 1'b0 : fire;
    end
  endtask

  task automatic edge_pulse(input string req);
    @(negedge clk) tick = 1'b1;
    model_edge();
    repeat (4) @(negedge clk);
    chk(req, int'(q), int'(m_q));
    tick = 1'b0;
    if (nv == 0) m_q = 1'b0;
    repeat (4) @(negedge clk);
    chk(req, int'(q), int'(m_q));
  endtask

  task automatic do_reload();
    @(negedge clk) reload = 1'b1;
    @(negedge clk) reload = 1'b0;
    m_cnt = nv;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_q = 1'b0;
    m_cnt = 5;
    @(negedge clk);
    chk("R10 reset q", int'(q), 0);

    // R10 + R3: from reset with N=5, 12 edges give 2 rises
    base = rises;
    for (int i = 0; i < 12; i++) edge_pulse("R3 N=5 step");
    chk("R3 N=5 rise count", rises - base, 2);

    // near-exhaustive sweep of small ratios (R3, R4, R5)
    for (int n = 1; n <= 6; n++) begin
      nv = n;
      do_reload();
      base = rises;
      for (int e = 1; e <= 2*n + 3; e++) begin
        edge_pulse(n == 1 ? "R5 toggle step" : "R4 one-period high");
        if (n == 1) chk("R5 rise count", rises - base, (e + 1) / 2);
        else        chk("R3 rise count", rises - base, e / n);
      end
    end

    // R2: disabled edges ignored, count does not advance
    nv = 3;
    do_reload();
    edge_pulse("R2 pre");
    en = 1'b0;
    base = rises;
    for (int i = 0; i < 6; i++) edge_pulse("R2 disabled edge");
    chk("R2 no rise while disabled", rises - base, 0);
    en = 1'b1;
    edge_pulse("R2 resume 2nd");
    chk("R2 count held", int'(q), 0);
    edge_pulse("R2 resume 3rd");
    chk("R2 fire on third counted", int'(q), 1);

    // R7/R8: reload while q high keeps q, then next counted edge clears
    do_reload();
    chk("R7 reload keeps q", int'(q), 1);
    edge_pulse("R8 clear after reload");
    chk("R8 cleared", int'(q), 0);
    edge_pulse("R8 second");
    chk("R8 not yet", int'(q), 0);
    edge_pulse("R8 third fires");
    chk("R8 fire after N edges", int'(q), 1);

    // R9: ratio changed mid-period
    nv = 4;
    do_reload();
    edge_pulse("R9 a");
    edge_pulse("R9 b");
    nv = 2;
    base = rises;
    for (int i = 0; i < 8; i++) edge_pulse("R9 new ratio");
    chk("R9 rise count", rises - base, 4);

    // R6: pass-through, gated by en
    nv = 0;
    base = rises;
    for (int i = 0; i < 5; i++) edge_pulse("R6 bypass follow");
    chk("R6 bypass rises", rises - base, 5);
    en = 1'b0;
    base = rises;
    for (int i = 0; i < 3; i++) edge_pulse("R6 bypass gated");
    chk("R6 gated rises", rises - base, 0);
    en = 1'b1;

    // R1: latency of three clk edges
    nv = 1;
    do_reload();
    m_q = q;
    @(negedge clk) tick = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 not before latency", int'(q), 0);
    @(negedge clk);
    chk("R1 at latency", int'(q), 1);
    @(negedge clk) tick = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule